// File: doc/BRIEF.md
# Byte-Port Digital I/O Controller

This block is a byte-wide register interface that controls 32 digital I/O lines, arranged as four 8-bit ports. Each port has an output latch. The port drives its pads only when two independent configuration layers both allow it. The first layer is a shared direction/buffer register, which holds one "output" bit and one "buffer off" bit per port. The second layer is a per-pair control register, which holds an input flag for each port of the pair and a commit bit. A control write takes effect only when the commit bit is set.

Software reads the pad levels back through a synchronizer. It also reads a board identification byte. The low five bits of that byte tell whether on-board digital I/O is fitted. The top three bits report which add-on module slots are empty.

The register bus has no back-pressure. Every strobe is accepted in the cycle it is sampled. Read data is registered and appears one cycle after the read strobe. It then holds until the next read.

Top module: `dio_byte_ctrl`

## Requirements
- R1: After reset, all output latches are 0 and all pad enables are 0. The direction/buffer register reads 0x33 (every buffer-off bit set, every output bit clear). Both control registers read 0x12 (all input flags set).
- R2: A write to a port data address loads that port's output latch. The port addresses are 0x80, 0x81, 0xC0 and 0xC1 for ports 0 to 3. The new value is on `pad_out` from the clock edge that samples the write.
- R3: A read of a port data address returns that port's pad levels as sampled SYNC_STAGES clocks before the read edge (default 2). This applies whether or not the port is driving.
- R4: The direction/buffer register at 0x82 is written and read back as a whole byte. Output bits are bit 2 (port 0), bit 3 (port 1), bit 6 (port 2) and bit 7 (port 3). Buffer-off bits are bit 0 (port 0), bit 1 (port 1), bit 4 (port 2) and bit 5 (port 3).
- R5: The control register at 0x83 covers ports 0 and 1. Bit 4 is the port 0 input flag and bit 1 is the port 1 input flag. Both are loaded only when bit 7 of the written byte is 1. A read returns the flags in the same positions, with all other bits 0.
- R6: The control register at 0xC3 covers ports 2 and 3. Bit 4 is the port 2 input flag and bit 1 is the port 3 input flag. Commit and readback work as in R5.
- R7: A control register write with bit 7 clear leaves both input flags and all pad enables unchanged.
- R8: All 8 enables of a port are 1 exactly when its output bit is 1, its buffer-off bit is 0 and its input flag is 0. Otherwise all 8 are 0.
- R9: Address 0x00 reads back as the identification byte. Its low 5 bits are 0x1D when on-board I/O is fitted and 0x1B when it is not. Bit 7 is `slot_empty[0]`, bit 6 is `slot_empty[1]` and bit 5 is `slot_empty[2]`.
- R10: Writes to address 0x00 or to unmapped addresses change no state. Reads of unmapped addresses return 0.
- R11: `bus_rdata` changes only on a clock edge that samples `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| slot_empty | input | 3 | Add-on slot empty flags, index 0 is slot 1 |
| pad_in | input | 32 | Pad levels, port p on bits 8p+7..8p |
| pad_out | output | 32 | Output latch values to the pads |
| pad_oe | output | 32 | Pad output enables |

## Verification
The drive enable is tried with every combination the two layers can form. This covers a port freed by both layers, a port blocked only by its buffer-off bit, a port blocked only by its input flag, and a port blocked only by a missing output bit. Each case separates a correct AND of the three conditions from a design that honours only one layer. Control writes are sent both with and without the commit bit, which shows whether the commit gate is decoded.

Pad readback is tried in two ways. With ports driving in loopback, a read shows that the latch value reaches the pins. With ports idle and an external pattern on the pads, a read shows the external level and the synchronizer delay. Identification and unmapped-address accesses use asymmetric bit patterns, so swapped slot bits or a decode that aliases addresses show up in the read data.

// File: rtl/dio_pkg.sv
package dio_pkg;

  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned BUS_W     = 8;

  typedef logic [BUS_W-1:0] bus_byte_t;

  // Register addresses
  localparam bus_byte_t A_IDENT  = 8'h00;
  localparam bus_byte_t A_PORT0  = 8'h80;
  localparam bus_byte_t A_PORT1  = 8'h81;
  localparam bus_byte_t A_DIRBUF = 8'h82;
  localparam bus_byte_t A_CTL_LO = 8'h83;
  localparam bus_byte_t A_PORT2  = 8'hC0;
  localparam bus_byte_t A_PORT3  = 8'hC1;
  localparam bus_byte_t A_CTL_HI = 8'hC3;

  // Control register fields
  localparam int unsigned CTL_COMMIT_BIT = 7;
  localparam int unsigned CTL_EVEN_BIT   = 4;
  localparam int unsigned CTL_ODD_BIT    = 1;

  localparam logic [4:0] IDENT_WITH_IO = 5'h1D;
  localparam logic [4:0] IDENT_NO_IO   = 5'h1B;

  localparam bus_byte_t DIRBUF_RESET = 8'h33;

  function automatic bus_byte_t port_addr(input int unsigned p);
    case (p)
      0:       port_addr = A_PORT0;
      1:       port_addr = A_PORT1;
      2:       port_addr = A_PORT2;
      default: port_addr = A_PORT3;
    endcase
  endfunction

  function automatic int unsigned out_bit_pos(input int unsigned p);
    out_bit_pos = (p < 2) ? (2 + p) : (6 + (p - 2));
  endfunction

  function automatic int unsigned bufoff_bit_pos(input int unsigned p);
    bufoff_bit_pos = (p < 2) ? p : (4 + (p - 2));
  endfunction

endpackage

// File: rtl/dio_cfg_regs.sv
module dio_cfg_regs
  import dio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  bus_byte_t            wr_addr,
  input  bus_byte_t            wr_data,
  output bus_byte_t            dirbuf_q,
  output logic [NUM_PORTS-1:0] in_flag_q
);

  localparam int unsigned NUM_PAIRS = NUM_PORTS / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirbuf_q <= DIRBUF_RESET;
    else if (wr_en && wr_addr == A_DIRBUF) dirbuf_q <= wr_data;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam bus_byte_t PAIR_ADDR = (g == 0) ? A_CTL_LO : A_CTL_HI;
    logic commit;
    assign commit = wr_en && wr_addr == PAIR_ADDR && wr_data[CTL_COMMIT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_flag_q[2*g]   <= 1'b1;
        in_flag_q[2*g+1] <= 1'b1;
      end else if (commit) begin
        in_flag_q[2*g]   <= wr_data[CTL_EVEN_BIT];
        in_flag_q[2*g+1] <= wr_data[CTL_ODD_BIT];
      end
    end

    // R7
    ignore_uncommitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == PAIR_ADDR && !wr_data[CTL_COMMIT_BIT])
        |=> $stable(in_flag_q[2*g+1:2*g]));

    // R5
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == PAIR_ADDR && wr_data[CTL_COMMIT_BIT])
        |=> (in_flag_q[2*g] == $past(wr_data[CTL_EVEN_BIT]) &&
             in_flag_q[2*g+1] == $past(wr_data[CTL_ODD_BIT])));
  end

  // R4
  dirbuf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIRBUF) |=> dirbuf_q == $past(wr_data));

endmodule

// File: rtl/dio_port_slice.sv
module dio_port_slice
  import dio_pkg::*;
#(
  parameter int unsigned PORT_IDX    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bus_byte_t         wr_addr,
  input  bus_byte_t         wr_data,
  input  logic              out_sel,
  input  logic              buf_off,
  input  logic              in_flag,
  input  logic [PORT_W-1:0] pin_lvl,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] pin_sync
);

  localparam bus_byte_t MY_ADDR = port_addr(PORT_IDX);

  logic drive;
  assign drive = out_sel & ~buf_off & ~in_flag;
  assign oe    = {PORT_W{drive}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_en && wr_addr == MY_ADDR) latch_q <= wr_data;
  end

  logic [SYNC_STAGES-1:0][PORT_W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= pin_lvl;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_sync = sync_q[SYNC_STAGES-1];

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MY_ADDR) |=> latch_q == $past(wr_data));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == MY_ADDR) |=> $stable(latch_q));

  // R8
  oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe == '0) || (oe == '1));

endmodule

// File: rtl/dio_read_mux.sv
module dio_read_mux
  import dio_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  bus_byte_t                   rd_addr,
  input  bus_byte_t                   ident,
  input  bus_byte_t                   dirbuf,
  input  logic [NUM_PORTS-1:0]        in_flag,
  input  logic [NUM_PORTS*PORT_W-1:0] pins,
  output bus_byte_t                   rdata
);

  function automatic bus_byte_t ctl_view(input logic even_f, input logic odd_f);
    bus_byte_t v;
    v = '0;
    v[CTL_EVEN_BIT] = even_f;
    v[CTL_ODD_BIT]  = odd_f;
    return v;
  endfunction

  bus_byte_t sel;

  always_comb begin
    sel = '0;
    case (rd_addr)
      A_IDENT:  sel = ident;
      A_DIRBUF: sel = dirbuf;
      A_CTL_LO: sel = ctl_view(in_flag[0], in_flag[1]);
      A_CTL_HI: sel = ctl_view(in_flag[2], in_flag[3]);
      A_PORT0:  sel = pins[0*PORT_W +: PORT_W];
      A_PORT1:  sel = pins[1*PORT_W +: PORT_W];
      A_PORT2:  sel = pins[2*PORT_W +: PORT_W];
      A_PORT3:  sel = pins[3*PORT_W +: PORT_W];
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R9
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_IDENT) |=> rdata == $past(ident));

endmodule

// File: rtl/dio_byte_ctrl.sv
module dio_byte_ctrl
  import dio_pkg::*;
#(
  parameter bit          HAS_IO      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  bus_addr,
  input  logic [7:0]                  bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [7:0]                  bus_rdata,
  input  logic [2:0]                  slot_empty,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe
);

  localparam logic [4:0] IDENT_LOW = HAS_IO ? IDENT_WITH_IO : IDENT_NO_IO;

  bus_byte_t                   ident;
  bus_byte_t                   dirbuf;
  logic [NUM_PORTS-1:0]        in_flag;
  logic [NUM_PORTS*PORT_W-1:0] pins_sync;

  assign ident = {slot_empty[0], slot_empty[1], slot_empty[2], IDENT_LOW};

  if (HAS_IO) begin : g_io
    dio_cfg_regs u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .wr_addr   (bus_addr),
      .wr_data   (bus_wdata),
      .dirbuf_q  (dirbuf),
      .in_flag_q (in_flag)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dio_port_slice #(
        .PORT_IDX    (p),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_slice (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .out_sel  (dirbuf[out_bit_pos(p)]),
        .buf_off  (dirbuf[bufoff_bit_pos(p)]),
        .in_flag  (in_flag[p]),
        .pin_lvl  (pad_in[p*PORT_W +: PORT_W]),
        .latch_q  (pad_out[p*PORT_W +: PORT_W]),
        .oe       (pad_oe[p*PORT_W +: PORT_W]),
        .pin_sync (pins_sync[p*PORT_W +: PORT_W])
      );
    end
  end else begin : g_no_io
    assign dirbuf    = '0;
    assign in_flag   = '0;
    assign pins_sync = '0;
    assign pad_out   = '0;
    assign pad_oe    = '0;
  end

  dio_read_mux u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd),
    .rd_addr (bus_addr),
    .ident   (ident),
    .dirbuf  (dirbuf),
    .in_flag (in_flag),
    .pins    (pins_sync),
    .rdata   (bus_rdata)
  );

  // R7
  uncommitted_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_CTL_LO || bus_addr == A_CTL_HI) &&
     !bus_wdata[CTL_COMMIT_BIT]) |=> $stable(pad_oe));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[6]  == 1'b1 && bus_addr[7] == 1'b0)
      |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/dio_byte_ctrl_tb.sv
module dio_byte_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [2:0]  slot_empty = 3'b110;
  logic [31:0] ext_lvl = '0;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  dio_byte_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .slot_empty (slot_empty),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  // Behavioural reference model
  logic [7:0]  m_lat [4];
  logic [7:0]  m_dir;
  bit          m_flag [4];
  logic [7:0]  m_rdata;
  logic [31:0] m_hist [$];

  function automatic logic [31:0] m_oe();
    logic [31:0] v = '0;
    bit [3:0] outb = {m_dir[7], m_dir[6], m_dir[3], m_dir[2]};
    bit [3:0] offb = {m_dir[5], m_dir[4], m_dir[1], m_dir[0]};
    for (int p = 0; p < 4; p++)
      if (outb[p] && !offb[p] && !m_flag[p]) v[p*8 +: 8] = 8'hFF;
    return v;
  endfunction

  function automatic logic [31:0] m_out();
    return {m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a, input logic [31:0] pins);
    case (a)
      8'h00: return {slot_empty[0], slot_empty[1], slot_empty[2], 5'h1D};
      8'h82: return m_dir;
      8'h83: return {3'b000, m_flag[0] ? 1'b1 : 1'b0, 2'b00, m_flag[1] ? 1'b1 : 1'b0, 1'b0};
      8'hC3: return {3'b000, m_flag[2] ? 1'b1 : 1'b0, 2'b00, m_flag[3] ? 1'b1 : 1'b0, 1'b0};
      8'h80: return pins[7:0];
      8'h81: return pins[15:8];
      8'hC0: return pins[23:16];
      8'hC1: return pins[31:24];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin m_lat[p] = '0; m_flag[p] = 1; end
      m_dir = 8'h33;
      m_rdata = '0;
      m_hist = {32'h0, 32'h0};
    end else begin
      logic [31:0] now_pins;
      now_pins = (m_oe() & m_out()) | (~m_oe() & ext_lvl);
      if (bus_rd) m_rdata = m_read(bus_addr, m_hist[0]);
      m_hist.push_back(now_pins);
      void'(m_hist.pop_front());
      if (bus_wr) begin
        case (bus_addr)
          8'h80: m_lat[0] = bus_wdata;
          8'h81: m_lat[1] = bus_wdata;
          8'hC0: m_lat[2] = bus_wdata;
          8'hC1: m_lat[3] = bus_wdata;
          8'h82: m_dir = bus_wdata;
          8'h83: if (bus_wdata[7]) begin m_flag[0] = bus_wdata[4]; m_flag[1] = bus_wdata[1]; end
          8'hC3: if (bus_wdata[7]) begin m_flag[2] = bus_wdata[4]; m_flag[3] = bus_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      n_checks++;
      if (pad_oe !== m_oe()) begin
        n_fail++;
        $display("FAIL R8 cycle %0d pad_oe actual %h expected %h", cyc, pad_oe, m_oe());
      end
      n_checks++;
      if (pad_out !== m_out()) begin
        n_fail++;
        $display("FAIL R2 cycle %0d pad_out actual %h expected %h", cyc, pad_out, m_out());
      end
      n_checks++;
      if (bus_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL R11 cycle %0d bus_rdata actual %h expected %h", cyc, bus_rdata, m_rdata);
      end
    end
    if (cyc > 5000 && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, {24'h0, bus_rdata}, {24'h0, exp});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    rd(8'h82, 8'h33, "R1 dirbuf reset");
    rd(8'h83, 8'h12, "R1 ctl lo reset");
    rd(8'hC3, 8'h12, "R1 ctl hi reset");
    // R9 identification
    rd(8'h00, 8'h7D, "R9 ident");
    // R2 latches
    wr(8'h80, 8'hA5); wr(8'h81, 8'h3C); wr(8'hC0, 8'hF0); wr(8'hC1, 8'h0F);
    check("R2 pad_out", pad_out, 32'h0FF03CA5);
    check("R8 no drive yet", pad_oe, 32'h0);
    // R5 R6 commit clear flags, R4 dir
    wr(8'h83, 8'h80); wr(8'hC3, 8'h80);
    check("R8 dir still off", pad_oe, 32'h0);
    wr(8'h82, 8'h44);
    check("R4 R8 ports 0 and 2", pad_oe, 32'h00FF00FF);
    rd(8'h82, 8'h44, "R4 dirbuf readback");
    wr(8'h82, 8'h45);
    check("R8 buffer off port0", pad_oe, 32'h00FF0000);
    wr(8'h82, 8'hCC);
    check("R8 all drive", pad_oe, 32'hFFFFFFFF);
    idle(3);
    rd(8'h81, 8'h3C, "R3 loopback port1");
    // R6 port3 input flag
    wr(8'hC3, 8'h82);
    check("R6 port3 input", pad_oe, 32'h00FFFFFF);
    rd(8'hC3, 8'h02, "R6 ctl hi readback");
    // R7 uncommitted write ignored
    wr(8'h83, 8'h10);
    check("R7 oe unchanged", pad_oe, 32'h00FFFFFF);
    rd(8'h83, 8'h00, "R7 flags unchanged");
    // R5 committed port0 input
    wr(8'h83, 8'h90);
    check("R5 port0 input", pad_oe, 32'h00FFFF00);
    rd(8'h83, 8'h10, "R5 ctl lo readback");
    // R3 external levels on idle ports
    @(negedge clk) ext_lvl = 32'h12345678;
    idle(3);
    rd(8'hC1, 8'h12, "R3 port3 external");
    rd(8'h80, 8'h78, "R3 port0 external");
    // R10 unmapped and ident writes
    wr(8'h40, 8'h55); wr(8'h84, 8'hFF); wr(8'h00, 8'h00);
    check("R10 oe unchanged", pad_oe, 32'h00FFFF00);
    check("R10 out unchanged", pad_out, 32'h0FF03CA5);
    rd(8'h40, 8'h00, "R10 unmapped read");
    rd(8'h00, 8'h7D, "R10 R9 ident after write");
    // R11 hold
    idle(4);
    check("R11 rdata held", {24'h0, bus_rdata}, 32'h7D);
    // R2 R3 latch change while driving
    wr(8'h81, 8'h99);
    check("R2 new latch", pad_out, 32'h0FF099A5);
    idle(3);
    rd(8'h81, 8'h99, "R3 loopback new value");
    // R9 other slot pattern
    @(negedge clk) slot_empty = 3'b001;
    rd(8'h00, 8'h9D, "R9 ident slot1 empty");
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule